// File: doc/BRIEF.md
# Energy-to-Frequency Calibration Pulse Generator

This block converts a stream of single-cycle pulses, one per energy LSB, into a pulsed output whose rate follows the measured power. Meter test equipment counts this output to check a meter's calibration. Two 12-bit unsigned scale values set a rational divide. Each accepted input pulse adds (scale numerator + 1) to a 13-bit phase accumulator. The block raises an output event each time the accumulator reaches (scale denominator + 1), and then subtracts that amount. A scale value of 0 is treated as 1. A ratio above one is limited to exactly one.

A shaper turns each output event into a pulse. The pulse is held for a fixed short width when both scale values are effectively 1. Otherwise it is held for a fixed long width when no period has been measured yet or when the measured period is slow. In all other cases it is held for half the measured event period. All timing runs on a clock enable at one quarter of the core clock, called a tick below. An event that arrives while a pulse is still high waits in a one-deep queue.

Top module: `cal_pulse_gen`

## Requirements
- R1: While reset is applied and after it is released, with no input pulses, `cf_out` stays low.
- R2: With numerator N and denominator D (N+1 <= D+1), K accepted input pulses from a zero accumulator give exactly floor(K*(N+1)/(D+1)) output pulses, provided no events overlap.
- R3: A scale value of 0 acts as 1. With both values at 0 the ratio is one, so every accepted input pulse gives one output pulse.
- R4: If (N+1) exceeds (D+1), the ratio is limited to one, so every accepted input pulse gives one output event.
- R5: Scale writes (`cfg_wr`, `cfg_sel` 0 = numerator, 1 = denominator) are used from the next accepted input pulse on. The width mode uses the values captured at that pulse.
- R6: `e_pulse` is only counted in cycles where `tick_en` is high. It is ignored in all other cycles.
- R7: When both captured scale values are effectively 1, every output pulse is high for SHORT_W ticks. This rule takes priority over the others.
- R8: Otherwise, the first output pulse after reset is high for LONG_W ticks.
- R9: Otherwise, the period P is measured in ticks between the last two events. If P > 2*LONG_W the pulse is high for LONG_W ticks. If not, it is high for max(floor(P/2),1) ticks.
- R10: An event that arrives while a pulse is high is queued, at most one deep, and further events are dropped. The queued pulse starts after exactly one low tick.
- R11: The phase accumulator never holds a value above 4095.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_en | input | 1 | Quarter-rate clock enable |
| e_pulse | input | 1 | Energy LSB pulse, counted when tick_en is high |
| cfg_wr | input | 1 | Scale register write strobe |
| cfg_sel | input | 1 | 0 selects numerator, 1 selects denominator |
| cfg_data | input | 12 | Scale value to write |
| cf_out | output | 1 | Shaped calibration pulse output |

## Verification
The assertions assume three things about the inputs: `tick_en` is high in at most one of each four cycles, `e_pulse` matters only in tick cycles, and events arrive through the scaler's registered output rather than directly. The bench drives `tick_en` itself at exactly one cycle in four. It places every counted input pulse on a tick cycle, and it places the pulses meant to be ignored only on cycles where `tick_en` is low. Pulse spacings are chosen so that the long, halved-period and short widths each appear. Close spacings are used on purpose only in the queueing test.

// File: rtl/cpg_pkg.sv
package cpg_pkg;
  parameter int REG_W = 12;
  localparam int ACC_W = REG_W + 1;

  typedef struct packed {
    logic [REG_W-1:0] num;
    logic [REG_W-1:0] den;
  } scale_cfg_t;
endpackage

// File: rtl/cpg_regs.sv
module cpg_regs
  import cpg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic             sel,
  input  logic [REG_W-1:0] data,
  input  logic             take,
  output scale_cfg_t       live,
  output scale_cfg_t       held
);
  scale_cfg_t live_d, held_d;

  always_comb begin
    live_d = live;
    held_d = held;
    if (take) held_d = live;
    if (wr) begin
      if (sel) live_d.den = data;
      else     live_d.num = data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live <= '0;
      held <= '0;
    end else begin
      live <= live_d;
      held <= held_d;
    end
  end
endmodule

// File: rtl/cpg_scaler.sv
module cpg_scaler
  import cpg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       qen,
  input  logic       epulse,
  input  scale_cfg_t cfg,
  output logic       ev
);
  logic [REG_W-1:0] n_eff, d_eff;
  logic [ACC_W-1:0] n1, d1, step, sum, acc_q, acc_d;
  logic             hit, ev_d;

  always_comb begin
    n_eff = (cfg.num == '0) ? REG_W'(1) : cfg.num;
    d_eff = (cfg.den == '0) ? REG_W'(1) : cfg.den;
    n1    = {1'b0, n_eff} + ACC_W'(1);
    d1    = {1'b0, d_eff} + ACC_W'(1);
    step  = (n1 > d1) ? d1 : n1;
    sum   = acc_q + step;
    hit   = (sum >= d1);
    acc_d = acc_q;
    ev_d  = ev;
    if (qen) begin
      ev_d = 1'b0;
      if (epulse) begin
        ev_d  = hit;
        acc_d = hit ? (sum - d1) : sum;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      ev    <= 1'b0;
    end else begin
      acc_q <= acc_d;
      ev    <= ev_d;
    end
  end

  // R11
  a_r11_acc_bound: assert property (@(posedge clk) disable iff (!rst_n)
    acc_q < ACC_W'(2**REG_W));
  // R4
  a_r4_ratio_clamp: assert property (@(posedge clk) disable iff (!rst_n)
    (qen && epulse && ((cfg.num == '0 ? REG_W'(1) : cfg.num) >=
                       (cfg.den == '0 ? REG_W'(1) : cfg.den))) |=> ev);
  // R6
  a_r6_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !qen |=> ($stable(acc_q) && $stable(ev)));
endmodule

// File: rtl/cpg_shaper.sv
module cpg_shaper
  import cpg_pkg::*;
#(
  parameter int SHORT_W = 16,
  parameter int LONG_W  = 80540
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       qen,
  input  logic       ev,
  input  scale_cfg_t cfg,
  output logic       pulse
);
  localparam int THR  = 2 * LONG_W;
  localparam int SAT  = THR + 1;
  localparam int CW   = $clog2(SAT + 1);
  localparam int MAXW = (LONG_W > SHORT_W) ? LONG_W : SHORT_W;
  localparam int RW   = $clog2(MAXW + 1);

  logic [CW-1:0] per_cnt, per_cnt_d, per_last, per_last_d, captured, per_now, half;
  logic          seen, seen_d, have_per, have_per_d, have_now;
  logic          active_d, pend, pend_d, both_one;
  logic [RW-1:0] rem, rem_d, width;

  always_comb begin
    captured = (per_cnt >= CW'(SAT)) ? CW'(SAT) : per_cnt + CW'(1);
    per_now  = ev ? captured : per_last;
    have_now = ev ? seen : have_per;
    half     = per_now >> 1;
    both_one = (cfg.num <= REG_W'(1)) && (cfg.den <= REG_W'(1));
    if (both_one)                             width = RW'(SHORT_W);
    else if (!have_now || per_now > CW'(THR)) width = RW'(LONG_W);
    else if (half == '0)                      width = RW'(1);
    else                                      width = RW'(half);
  end

  always_comb begin
    per_cnt_d  = per_cnt;
    per_last_d = per_last;
    seen_d     = seen;
    have_per_d = have_per;
    active_d   = pulse;
    rem_d      = rem;
    pend_d     = pend;
    if (qen) begin
      per_cnt_d = (per_cnt >= CW'(SAT)) ? CW'(SAT) : per_cnt + CW'(1);
      if (ev) begin
        per_cnt_d  = '0;
        per_last_d = captured;
        have_per_d = seen;
        seen_d     = 1'b1;
      end
      if (pulse) begin
        if (rem == RW'(1)) active_d = 1'b0;
        else               rem_d    = rem - RW'(1);
        if (ev) pend_d = 1'b1;
      end else if (pend || ev) begin
        active_d = 1'b1;
        rem_d    = width;
        pend_d   = pend && ev;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_cnt  <= '0;
      per_last <= '0;
      seen     <= 1'b0;
      have_per <= 1'b0;
      pulse    <= 1'b0;
      rem      <= '0;
      pend     <= 1'b0;
    end else begin
      per_cnt  <= per_cnt_d;
      per_last <= per_last_d;
      seen     <= seen_d;
      have_per <= have_per_d;
      pulse    <= active_d;
      rem      <= rem_d;
      pend     <= pend_d;
    end
  end

  // R10
  a_r10_queued_start: assert property (@(posedge clk) disable iff (!rst_n)
    (qen && pend && !pulse) |=> pulse);
  // R9
  a_r9_width_cap: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |-> (rem <= RW'(MAXW)));
  // R1
  a_r1_rest_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!pulse && !pend && !ev) |=> !pulse);
endmodule

// File: rtl/cal_pulse_gen.sv
module cal_pulse_gen
  import cpg_pkg::*;
#(
  parameter int SHORT_W = 16,
  parameter int LONG_W  = 80540
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             e_pulse,
  input  logic             cfg_wr,
  input  logic             cfg_sel,
  input  logic [REG_W-1:0] cfg_data,
  output logic             cf_out
);
  logic [1:0] rst_sync;
  logic       rst_i, take, ev;
  scale_cfg_t live, held;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i = rst_sync[1];
  assign take  = tick_en && e_pulse;

  cpg_regs u_regs (
    .clk(clk), .rst_n(rst_i), .wr(cfg_wr), .sel(cfg_sel), .data(cfg_data),
    .take(take), .live(live), .held(held)
  );

  cpg_scaler u_scaler (
    .clk(clk), .rst_n(rst_i), .qen(tick_en), .epulse(e_pulse), .cfg(live), .ev(ev)
  );

  cpg_shaper #(.SHORT_W(SHORT_W), .LONG_W(LONG_W)) u_shaper (
    .clk(clk), .rst_n(rst_i), .qen(tick_en), .ev(ev), .cfg(held), .pulse(cf_out)
  );
endmodule

// File: tb/cal_pulse_gen_test.sv
module cal_pulse_gen_test;
  localparam int SW = 16;
  localparam int LW = 40;

  logic clk = 1'b0, rst_n = 1'b0, tick_en = 1'b0, e_pulse = 1'b0;
  logic cfg_wr = 1'b0, cfg_sel = 1'b0;
  logic [11:0] cfg_data = '0;
  logic cf_out;
  logic [1:0] qc = '0;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  cal_pulse_gen #(.SHORT_W(SW), .LONG_W(LW)) uut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .e_pulse(e_pulse),
    .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_data(cfg_data), .cf_out(cf_out)
  );

  always #10 clk = ~clk;

  always @(negedge clk) begin
    qc      <= qc + 2'd1;
    tick_en <= (qc == 2'd3);
  end

  // reference model, one step per tick
  int m_num, m_den, m_lnum, m_lden, m_acc, m_pc, m_pl, m_rem;
  bit m_ev, m_seen, m_hp, m_act, m_pend;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_num = 0; m_den = 0; m_lnum = 0; m_lden = 0; m_acc = 0;
      m_pc = 0; m_pl = 0; m_rem = 0;
      m_ev = 0; m_seen = 0; m_hp = 0; m_act = 0; m_pend = 0;
    end else begin
      if (tick_en) begin
        int cap, pn, w, n1, d1;
        bit hn, ev_in, nev;
        ev_in = m_ev;
        cap = (m_pc >= 2*LW+1) ? 2*LW+1 : m_pc + 1;
        pn  = ev_in ? cap : m_pl;
        hn  = ev_in ? m_seen : m_hp;
        if (m_lnum <= 1 && m_lden <= 1) w = SW;
        else if (!hn || pn > 2*LW)      w = LW;
        else                             w = (pn/2 < 1) ? 1 : pn/2;
        m_pc = (m_pc >= 2*LW+1) ? 2*LW+1 : m_pc + 1;
        if (ev_in) begin m_pc = 0; m_pl = cap; m_hp = m_seen; m_seen = 1; end
        if (m_act) begin
          if (m_rem == 1) m_act = 0; else m_rem--;
          if (ev_in) m_pend = 1;
        end else if (m_pend || ev_in) begin
          m_act = 1; m_rem = w; m_pend = m_pend && ev_in;
        end
        nev = 0;
        if (e_pulse) begin
          n1 = ((m_num == 0) ? 1 : m_num) + 1;
          d1 = ((m_den == 0) ? 1 : m_den) + 1;
          if (n1 > d1) n1 = d1;
          m_lnum = m_num; m_lden = m_den;
          m_acc += n1;
          if (m_acc >= d1) begin m_acc -= d1; nev = 1; end
        end
        m_ev = nev;
      end
      if (cfg_wr) begin
        if (cfg_sel) m_den = cfg_data; else m_num = cfg_data;
      end
    end
  end

  // output monitor
  int mism = 0, mis_a = 0, mis_e = 0, rises = 0;
  int hi_len = 0, lo_len = 0, last_hi = 0, last_lo = 0, first_hi = -1;
  logic prev = 1'b0;

  always @(negedge clk) begin
    if (cf_out !== m_act) begin
      if (mism == 0) begin mis_a = cf_out; mis_e = m_act; end
      mism++;
    end
    if (cf_out && !prev) begin rises++; last_lo = lo_len; lo_len = 0; end
    if (!cf_out && prev) begin
      last_hi = hi_len; hi_len = 0;
      if (first_hi < 0) first_hi = last_hi;
    end
    if (cf_out) hi_len++; else lo_len++;
    prev = cf_out;
  end

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic phase_start();
    mism = 0; rises = 0; first_hi = -1;
  endtask

  task automatic phase_end(string req);
    check(mism == 0, req, "model agreement", mis_a, mis_e);
  endtask

  task automatic wait_q();
    do begin @(negedge clk); #1; end while (!tick_en);
  endtask

  task automatic pulse_at(int gap);
    repeat (gap) wait_q();
    e_pulse = 1'b1;
    @(negedge clk); #1 e_pulse = 1'b0;
  endtask

  task automatic write_cfg(bit sel, int val);
    @(negedge clk); #1;
    cfg_wr = 1'b1; cfg_sel = sel; cfg_data = 12'(val);
    @(negedge clk); #1 cfg_wr = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); #1 rst_n = 1'b0;
    repeat (5) @(negedge clk);
    #1 rst_n = 1'b1;
    repeat (40) @(negedge clk);
    #1;
  endtask

  initial begin
    do_reset();

    // R1: quiet after reset
    phase_start();
    check(cf_out == 1'b0, "R1", "output after reset", cf_out, 0);
    repeat (20) wait_q();
    check(rises == 0, "R1", "pulses while idle", rises, 0);
    phase_end("R1");

    // R3 / R7: both scales 0 -> ratio one, short width
    phase_start();
    repeat (3) pulse_at(30);
    repeat (30) wait_q();
    check(rises == 3, "R3", "pulses with zero scales", rises, 3);
    check(last_hi == 4*SW, "R7", "short width clocks", last_hi, 4*SW);
    phase_end("R7");

    // R9: half-period width (num=2, den=2)
    phase_start();
    write_cfg(0, 2); write_cfg(1, 2);
    repeat (4) pulse_at(30);
    repeat (30) wait_q();
    check(rises == 4, "R9", "pulses at ratio one", rises, 4);
    check(last_hi == 4*15, "R9", "half period width clocks", last_hi, 60);
    phase_end("R9");

    // R5: new scales take effect from the next pulse
    phase_start();
    write_cfg(0, 1); write_cfg(1, 1);
    pulse_at(30);
    repeat (30) wait_q();
    check(rises == 1, "R5", "pulse after rewrite", rises, 1);
    check(last_hi == 4*SW, "R5", "width after rewrite", last_hi, 4*SW);
    phase_end("R5");

    // R4: clamp, and R9 slow period -> long width
    phase_start();
    write_cfg(0, 9); write_cfg(1, 3);
    repeat (4) pulse_at(100);
    repeat (60) wait_q();
    check(rises == 4, "R4", "clamped ratio pulses", rises, 4);
    check(last_hi == 4*LW, "R9", "slow period width clocks", last_hi, 4*LW);
    phase_end("R4");

    // R2: ratio 3/7 over 14 pulses
    phase_start();
    write_cfg(0, 2); write_cfg(1, 6);
    repeat (14) pulse_at(30);
    repeat (60) wait_q();
    check(rises == 6, "R2", "scaled output count", rises, 6);
    phase_end("R2");

    // R6: pulses outside tick cycles are ignored
    phase_start();
    write_cfg(0, 0); write_cfg(1, 0);
    for (int i = 0; i < 5; i++) begin
      do begin @(negedge clk); #1; end while (tick_en);
      e_pulse = 1'b1;
      @(negedge clk); #1 e_pulse = 1'b0;
      if (tick_en) begin @(negedge clk); #1; end
    end
    repeat (30) wait_q();
    check(rises == 0, "R6", "pulses from off-tick input", rises, 0);
    phase_end("R6");

    // R8 / R10: first pulse long, queue one, drop third
    do_reset();
    phase_start();
    write_cfg(0, 4); write_cfg(1, 4);
    pulse_at(1);
    pulse_at(5);
    pulse_at(5);
    repeat (80) wait_q();
    check(first_hi == 4*LW, "R8", "first pulse width clocks", first_hi, 4*LW);
    check(rises == 2, "R10", "pulses with one queued", rises, 2);
    check(last_lo == 4, "R10", "gap before queued pulse clocks", last_lo, 4);
    check(last_hi == 8, "R10", "queued pulse width clocks", last_hi, 8);
    phase_end("R10");

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule